// File: doc/BRIEF.md
# Mixed-Precision Integer Dot-Product Accumulator

This block is a vector datapath for neural-network inference. It multiplies narrow integer lanes from two packed operand vectors and adds the products into a vector of signed 32-bit accumulator lanes. Each 32-bit lane is independent. It gathers either four byte products (first operand unsigned 8-bit, second operand signed 8-bit) or two signed 16-bit products, and adds them to the matching lane of the incoming accumulator vector.

Four operation modes are selected per request. Two of them are staged and take one clock per step. The staged byte mode forms saturated signed 16-bit pair sums, widens adjacent pairs into 32-bit lanes, then adds the accumulator. The staged halfword mode forms 32-bit pair sums, then adds the accumulator. The other two modes are fused and finish in a single cycle. The fused byte mode has no intermediate saturation. A request is taken when `in_valid` and `in_ready` are both high. The result appears on `out_acc` with a one-cycle `out_valid` pulse and stays there until the next result.

The vector width is a parameter and must be a multiple of 32 bits. The default is 512 bits, which gives 64 byte lanes, or 32 halfword lanes, feeding 16 accumulator lanes.

Top module: `dpa_dot_accum`

## Requirements
- R1: After synchronous active-low reset, `in_ready` is 1, `out_valid` is 0 and `out_acc` is all zeros.
- R2: Mode code 0 (staged byte). For accumulator lane j, byte i (0..3) of each operand sits at bits [32j+8i+7 : 32j+8i]. `in_a` bytes are unsigned and `in_b` bytes are signed. The byte products of pair {0,1} and of pair {2,3} are each summed and saturated to -32768..32767. The two saturated sums are added to the lane.
- R3: A mode-0 request gives `out_valid` on the third rising edge counting the accept edge. `in_ready` is low for the two cycles in between.
- R4: Mode code 1 (staged halfword). Halfword h (0..1) of lane j sits at bits [32j+16h+15 : 32j+16h]. Both operands are signed. The two products are summed modulo 2^32 and added to the lane.
- R5: A mode-1 request gives `out_valid` on the second rising edge counting the accept edge. `in_ready` is low in between.
- R6: Mode code 2 (fused byte). All four unsigned-by-signed byte products of a lane are added to the lane with no intermediate saturation.
- R7: Mode code 3 (fused halfword). It gives the same lane value as R4.
- R8: Mode codes 2 and 3 give `out_valid` on the accept edge. `in_ready` stays high, so requests may follow on every cycle.
- R9: Every addition into an accumulator lane wraps modulo 2^32 and never saturates.
- R10: The mode is taken from `in_mode` at the accept edge: 0 staged byte, 1 staged halfword, 2 fused byte, 3 fused halfword.
- R11: `out_acc` holds its value in every cycle where `out_valid` is low.
- R12: `in_valid` asserted while `in_ready` is low is ignored. It produces no result and does not disturb the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_mode | input | 2 | Operation mode code |
| in_a | input | VEC_W | First operand vector (unsigned bytes or signed halfwords) |
| in_b | input | VEC_W | Second operand vector (signed bytes or signed halfwords) |
| in_acc | input | VEC_W | Incoming accumulator vector, signed 32-bit lanes |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_acc | output | VEC_W | Updated accumulator vector |

## Verification
The latency properties assume that `in_mode` is a defined two-bit value whenever `in_valid` and `in_ready` are both high. They also assume that the requester never withdraws a request it has raised. The bench drives every request from a task that waits at the falling edge for `in_ready`. It applies only the four defined codes, and it raises `in_valid` during busy cycles only on purpose, to exercise the ignore rule. Operand values cover random lanes and the extremes 0, 255, -128, 127 and -32768, so that saturation and modulo wrap both occur. Each accepted request is compared with a behavioural reference model.

// File: rtl/dpa_pkg.sv
// Package: shared mode codes, step encoding and the 16-bit saturation helper
// for the dot-product accumulator. Assumes two-bit mode codes from the requester.
package dpa_pkg;

    typedef enum logic [1:0] {
        MODE_U8_STAGED  = 2'd0,
        MODE_S16_STAGED = 2'd1,
        MODE_U8_FUSED   = 2'd2,
        MODE_S16_FUSED  = 2'd3
    } dpa_mode_e;

    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,
        STEP_WIDEN = 2'd1,
        STEP_ADD   = 2'd2
    } dpa_step_e;

    // Clamp an 18-bit signed pair sum into the signed 16-bit range.
    function automatic logic [15:0] sat16(input logic signed [17:0] x);
        if (x > 18'sd32767) begin
            return 16'h7FFF;
        end else if (x < -18'sd32768) begin
            return 16'h8000;
        end else begin
            return x[15:0];
        end
    endfunction

endpackage

// File: rtl/dpa_u8_pair_sat.sv
// Module: forms, for every 16-bit slot, the sum of two unsigned-byte by
// signed-byte products saturated to signed 16 bits (first staged byte step).
// Assumes VEC_W is a multiple of 16.
module dpa_u8_pair_sat #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] op_u,
    input  logic [VEC_W-1:0] op_s,
    output logic [VEC_W-1:0] half_sums
);
    import dpa_pkg::*;

    localparam int HALVES = VEC_W / 16;

    for (genvar k = 0; k < HALVES; k++) begin : g_half
        logic signed [16:0] prod_lo;
        logic signed [16:0] prod_hi;
        logic signed [17:0] pair;

        // Exact byte products, both sign-extended to 17 bits.
        assign prod_lo = $signed({9'd0, op_u[16*k +: 8]})
                       * $signed({{9{op_s[16*k+7]}}, op_s[16*k +: 8]});
        assign prod_hi = $signed({9'd0, op_u[16*k+8 +: 8]})
                       * $signed({{9{op_s[16*k+15]}}, op_s[16*k+8 +: 8]});
        // Pair sum without loss, then clamp.
        assign pair = $signed({prod_lo[16], prod_lo}) + $signed({prod_hi[16], prod_hi});
        assign half_sums[16*k +: 16] = sat16(pair);
    end

endmodule

// File: rtl/dpa_s16_pair_dot.sv
// Module: for every 32-bit lane, sums the two signed 16-bit by signed 16-bit
// products modulo 2^32. Used by both halfword modes. Assumes VEC_W % 32 == 0.
module dpa_s16_pair_dot #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    output logic [VEC_W-1:0] lane_dot
);
    localparam int LANES = VEC_W / 32;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic signed [31:0] prod_lo;
        logic signed [31:0] prod_hi;

        // Halfword products always fit 32 bits; only their sum can wrap.
        assign prod_lo = $signed({{16{op_a[32*j+15]}}, op_a[32*j +: 16]})
                       * $signed({{16{op_b[32*j+15]}}, op_b[32*j +: 16]});
        assign prod_hi = $signed({{16{op_a[32*j+31]}}, op_a[32*j+16 +: 16]})
                       * $signed({{16{op_b[32*j+31]}}, op_b[32*j+16 +: 16]});
        assign lane_dot[32*j +: 32] = prod_lo + prod_hi;
    end

endmodule

// File: rtl/dpa_half_widen.sv
// Module: second staged byte step. Scales each signed 16-bit slot by a
// broadcast one and sums adjacent slots into a signed 32-bit lane.
// Assumes VEC_W % 32 == 0.
module dpa_half_widen #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] half_sums,
    output logic [VEC_W-1:0] lane_sum
);
    localparam int LANES = VEC_W / 32;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [31:0] lo_ext;
        logic [31:0] hi_ext;

        // Multiplying by one reduces to sign extension.
        assign lo_ext = {{16{half_sums[32*j+15]}}, half_sums[32*j +: 16]};
        assign hi_ext = {{16{half_sums[32*j+31]}}, half_sums[32*j+16 +: 16]};
        assign lane_sum[32*j +: 32] = lo_ext + hi_ext;
    end

endmodule

// File: rtl/dpa_fused_dot.sv
// Module: single-step lanes. Adds either the unsaturated four-byte dot
// product or the supplied halfword dot product into the accumulator,
// wrapping modulo 2^32. Assumes VEC_W % 32 == 0.
module dpa_fused_dot #(
    parameter int VEC_W = 512
) (
    input  logic             sel_half,
    input  logic [VEC_W-1:0] op_u,
    input  logic [VEC_W-1:0] op_s,
    input  logic [VEC_W-1:0] half_dot,
    input  logic [VEC_W-1:0] acc_in,
    output logic [VEC_W-1:0] acc_out
);
    localparam int LANES = VEC_W / 32;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [31:0] byte_prod [4];
        logic [31:0] byte_dot;

        for (genvar i = 0; i < 4; i++) begin : g_byte
            // Each exact byte product, sign-extended to the lane width.
            assign byte_prod[i] = $signed({24'd0, op_u[32*j+8*i +: 8]})
                                * $signed({{24{op_s[32*j+8*i+7]}}, op_s[32*j+8*i +: 8]});
        end

        // Four products together need at most 18 bits: no saturation.
        assign byte_dot = byte_prod[0] + byte_prod[1] + byte_prod[2] + byte_prod[3];
        assign acc_out[32*j +: 32] = acc_in[32*j +: 32]
                                   + (sel_half ? half_dot[32*j +: 32] : byte_dot);
    end

endmodule

// File: rtl/dpa_seq.sv
// Module: step sequencer. Idle accepts a request. Staged byte walks
// widen then add, staged halfword goes straight to add, fused modes stay idle.
// Assumes in_mode is a defined code when a request is taken.
module dpa_seq (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    output logic              in_ready,
    output dpa_pkg::dpa_step_e step
);
    import dpa_pkg::*;

    dpa_step_e step_q;
    dpa_step_e step_d;

    assign in_ready = (step_q == STEP_IDLE);
    assign step     = step_q;

    // Next-step selection.
    always_comb begin
        step_d = step_q;
        case (step_q)
            STEP_IDLE: begin
                if (in_valid) begin
                    case (dpa_mode_e'(in_mode))
                        MODE_U8_STAGED:  step_d = STEP_WIDEN;
                        MODE_S16_STAGED: step_d = STEP_ADD;
                        default:         step_d = STEP_IDLE;
                    endcase
                end
            end
            STEP_WIDEN: step_d = STEP_ADD;
            default:    step_d = STEP_IDLE;
        endcase
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_IDLE;
        end else begin
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/dpa_dot_accum.sv
// Module: top of the mixed-precision dot-product accumulator. Holds the
// staged intermediate and accumulator copies, selects the step result and
// registers the output vector. Assumes VEC_W is a multiple of 32 and that
// the requester holds a request until it is accepted.
module dpa_dot_accum #(
    parameter int VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_mode,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [VEC_W-1:0] in_acc,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_acc
);
    import dpa_pkg::*;

    localparam int LANES = VEC_W / 32;

    if (VEC_W % 32 != 0) begin : g_bad_width
        $error("VEC_W must be a multiple of 32");
    end

    dpa_step_e        step;
    logic             accept;
    logic [VEC_W-1:0] half_sat;
    logic [VEC_W-1:0] half_dot;
    logic [VEC_W-1:0] widened;
    logic [VEC_W-1:0] fused;
    logic [VEC_W-1:0] staged_sum;
    logic [VEC_W-1:0] mid_q;
    logic [VEC_W-1:0] acc_q;

    assign accept = in_valid && in_ready;

    dpa_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_mode  (in_mode),
        .in_ready (in_ready),
        .step     (step)
    );

    dpa_u8_pair_sat #(.VEC_W(VEC_W)) u_pair_sat (
        .op_u      (in_a),
        .op_s      (in_b),
        .half_sums (half_sat)
    );

    dpa_s16_pair_dot #(.VEC_W(VEC_W)) u_half_dot (
        .op_a     (in_a),
        .op_b     (in_b),
        .lane_dot (half_dot)
    );

    dpa_half_widen #(.VEC_W(VEC_W)) u_widen (
        .half_sums (mid_q),
        .lane_sum  (widened)
    );

    dpa_fused_dot #(.VEC_W(VEC_W)) u_fused (
        .sel_half (in_mode[0]),
        .op_u     (in_a),
        .op_s     (in_b),
        .half_dot (half_dot),
        .acc_in   (in_acc),
        .acc_out  (fused)
    );

    // Final staged step: lane-wise wrapping add of intermediate and accumulator.
    for (genvar j = 0; j < LANES; j++) begin : g_add
        assign staged_sum[32*j +: 32] = mid_q[32*j +: 32] + acc_q[32*j +: 32];
    end

    // Datapath registers: capture step one, run the widen/add steps, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q     <= '0;
            acc_q     <= '0;
            out_acc   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                case (dpa_mode_e'(in_mode))
                    MODE_U8_STAGED: begin
                        mid_q <= half_sat;
                        acc_q <= in_acc;
                    end
                    MODE_S16_STAGED: begin
                        mid_q <= half_dot;
                        acc_q <= in_acc;
                    end
                    default: begin
                        out_acc   <= fused;
                        out_valid <= 1'b1;
                    end
                endcase
            end else if (step == STEP_WIDEN) begin
                mid_q <= widened;
            end else if (step == STEP_ADD) begin
                out_acc   <= staged_sum;
                out_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpa_dot_accum_chk.sv
// Module: protocol and latency checker for dpa_dot_accum, bound to every
// instance. Assumes in_mode is a defined code on each accepted request.
module dpa_dot_accum_chk #(
    parameter int VEC_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_acc
);

    AST_STAGED_U8_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'd0) |=> (!in_ready && !out_valid) ##1 (!in_ready && !out_valid) ##1 out_valid); // R3

    AST_STAGED_S16_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'd1) |=> (!in_ready && !out_valid) ##1 out_valid); // R5

    AST_FUSED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode[1]) |=> (out_valid && in_ready)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_acc)); // R11

    AST_BUSY_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !$past(in_ready) && in_valid) |=> !in_ready || out_valid); // R12

endmodule

bind dpa_dot_accum dpa_dot_accum_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_acc   (out_acc)
);

// File: tb/tb_dpa_dot_accum.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes reference results, the monitor pops them.
module tb_dpa_dot_accum;
    localparam int VEC_W = 512;
    localparam int LANES = VEC_W / 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [1:0]       in_mode;
    logic [VEC_W-1:0] in_a, in_b, in_acc;
    logic             out_valid;
    logic [VEC_W-1:0] out_acc;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pulses = 0;
    int issued = 0;
    bit timed_out = 0;
    logic [VEC_W-1:0] last_exp = '0;

    typedef struct {
        logic [VEC_W-1:0] exp;
        int               due;
        string            tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    dpa_dot_accum #(.VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
        .out_valid(out_valid), .out_acc(out_acc)
    );

    // Behavioural reference built from the requirements.
    function automatic logic [VEC_W-1:0] ref_model(input int mode,
            input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input logic [VEC_W-1:0] acc);
        logic [VEC_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            longint s;
            longint h;
            s = 0;
            if (mode == 0 || mode == 2) begin
                for (int p = 0; p < 2; p++) begin
                    h = 0;
                    for (int q = 0; q < 2; q++) begin
                        int i;
                        i = 4 * l + 2 * p + q;
                        h += longint'(a[8*i +: 8]) * longint'($signed(b[8*i +: 8]));
                    end
                    if (mode == 0 && h > 32767) h = 32767;
                    if (mode == 0 && h < -32768) h = -32768;
                    s += h;
                end
            end else begin
                for (int q = 0; q < 2; q++) begin
                    s += longint'($signed(a[32*l+16*q +: 16])) * longint'($signed(b[32*l+16*q +: 16]));
                end
            end
            r[32*l +: 32] = 32'(longint'($signed(acc[32*l +: 32])) + s);
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] fill8(input logic [7:0] x);
        return {(VEC_W/8){x}};
    endfunction

    function automatic logic [VEC_W-1:0] fill16(input logic [15:0] x);
        return {(VEC_W/16){x}};
    endfunction

    function automatic logic [VEC_W-1:0] fill32(input logic [31:0] x);
        return {(VEC_W/32){x}};
    endfunction

    function automatic logic [VEC_W-1:0] rand_vec();
        logic [VEC_W-1:0] v;
        for (int k = 0; k < VEC_W / 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // Byte vector drawn from extreme values only.
    function automatic logic [VEC_W-1:0] extreme_vec();
        logic [VEC_W-1:0] v;
        logic [7:0] pick [4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
        for (int k = 0; k < VEC_W / 8; k++) v[8*k +: 8] = pick[$urandom_range(0, 3)];
        return v;
    endfunction

    // Driver: called at a falling edge, waits for ready, presents one request
    // and pushes its expected result. noise raises in_valid during busy cycles.
    task automatic issue(input int mode, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                         input logic [VEC_W-1:0] acc, input string tag, input bit noise);
        sb_item_t it;
        int lat;
        while (!in_ready) @(negedge clk);
        lat = (mode == 0) ? 3 : (mode == 1) ? 2 : 1;
        in_valid = 1'b1;
        in_mode  = 2'(mode);
        in_a = a; in_b = b; in_acc = acc;
        it.exp = ref_model(mode, a, b, acc);
        it.due = cyc + lat;
        it.tag = tag;
        sb.push_back(it);
        issued++;
        @(negedge clk);
        in_valid = 1'b0;
        if (noise) begin
            // R12: junk request while busy must be dropped.
            in_valid = 1'b1;
            in_mode  = 2'd2;
            in_a = ~a; in_b = ~b; in_acc = ~acc;
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares each result pulse with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            sb_item_t it;
            pulses++;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected result got %h exp none", out_acc);
            end else begin
                it = sb.pop_front();
                if (out_acc !== it.exp) begin
                    fails++;
                    $display("FAIL %s data got %h exp %h", it.tag, out_acc, it.exp);
                end
                checks++;
                if (cyc != it.due) begin
                    fails++;
                    $display("FAIL %s latency got cycle %0d exp %0d", it.tag, cyc, it.due);
                end
                last_exp = it.exp;
            end
        end
    end

    task automatic check_bit(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic run_all();
        string tags [4] = '{"R2 R3 R10", "R4 R5 R10", "R6 R8 R10", "R7 R8 R10"};
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0;
        in_a = '0; in_b = '0; in_acc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_bit(in_ready, 1'b1, "R1 in_ready");
        check_bit(out_valid, 1'b0, "R1 out_valid");
        checks++;
        if (out_acc !== '0) begin
            fails++;
            $display("FAIL R1 out_acc got %h exp 0", out_acc);
        end

        // R2 saturation at both ends, then zero
        issue(0, fill8(8'hFF), fill8(8'h80), fill32(32'd5), "R2 R3 sat low", 0);
        issue(0, fill8(8'hFF), fill8(8'h7F), fill32(32'hFFFF_FFF0), "R2 R3 sat high", 0);
        issue(0, fill8(8'h00), fill8(8'h80), fill32(32'h1234_5678), "R2 zero", 0);
        // R4 and R9: two -32768 squares wrap to 0x80000000
        issue(1, fill16(16'h8000), fill16(16'h8000), '0, "R4 R5 R9 wrap", 0);
        issue(3, fill16(16'h8000), fill16(16'h8000), fill32(32'h8000_0000), "R7 R9 wrap", 0);
        // R6 no intermediate clamp; R9 wrap on accumulate
        issue(2, fill8(8'hFF), fill8(8'h80), fill32(32'h8000_0000), "R6 R9 wrap low", 0);
        issue(2, fill8(8'hFF), fill8(8'h7F), fill32(32'h7FFF_FFF0), "R6 R9 wrap high", 0);

        // Random and extreme stimulus across all mode codes
        for (int i = 0; i < 48; i++) begin
            int m;
            m = i % 4;
            if (i % 3 == 0) issue(m, extreme_vec(), extreme_vec(), rand_vec(), tags[m], 0);
            else            issue(m, rand_vec(), rand_vec(), rand_vec(), tags[m], 0);
        end

        // R8 back-to-back fused requests
        for (int i = 0; i < 8; i++) begin
            issue(2 + (i % 2), rand_vec(), rand_vec(), rand_vec(), "R8 back-to-back", 0);
        end

        // R12 junk while busy in both staged modes
        issue(0, extreme_vec(), extreme_vec(), rand_vec(), "R12 staged byte", 1);
        issue(1, rand_vec(), rand_vec(), rand_vec(), "R12 staged half", 1);

        repeat (8) @(negedge clk);
        // R11 output holds while idle
        checks++;
        if (out_acc !== last_exp) begin
            fails++;
            $display("FAIL R11 hold got %h exp %h", out_acc, last_exp);
        end
        // R12 one result per accepted request
        checks++;
        if (pulses != issued || sb.size() != 0) begin
            fails++;
            $display("FAIL R12 result count got %0d exp %0d", pulses, issued);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog got timeout exp completion");
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule